// File: doc/BRIEF.md
# GPIO Interrupt Cause Controller

This block turns 32 asynchronous input lines into four interrupt requests. Each line passes through a synchroniser. It is then XORed with a per-line polarity bit to form a data-in word that software can read. Two cause paths start from that word.

- The level path is data-in gated by a level mask. It is combinational and holds no state.
- The edge path is a sticky register. A bit sets when the matching data-in bit goes from 0 to 1, and an edge mask gates the register's output.

The masked causes of each byte of lines are ORed into one request, so a handler knows which group of eight lines to scan.

Software programs the block through a simple register port. It writes the polarity, level-mask, edge-mask and edge-cause registers, and it reads every register including data-in. An edge cause is acknowledged by writing 0 to its bit. Writing 1 to a bit leaves it as it is, so one handler never clears another handler's pending cause.

Software can catch both edges of a line by flipping the line's polarity bit after each event. The flip inverts data-in, so the block suppresses edge detection on that line for the cycle in which the polarity bit changes. A polarity write on its own therefore never records an event.

Top module: `gpio_irq_cause`

## Requirements
- R1: After reset the polarity, edge mask, level mask and edge cause registers read as 0 and all of `irq_o` is 0.
- R2: Data-in bit n is the synchronised line n XOR polarity bit n. It is readable at offset 0x110 two clock edges after the line changes.
- R3: The level cause is data-in AND level mask (offset 0x11C). It is not latched, so the request drops as soon as data-in drops.
- R4: An edge cause bit (offset 0x114) sets on a 0-to-1 change of data-in and then holds. Polarity 0 (offset 0x10C) catches rising line edges and polarity 1 catches falling line edges.
- R5: A write to offset 0x114 clears each cause bit written as 0 and keeps each bit written as 1.
- R6: When an edge event and a clearing write reach the same cause bit on the same clock edge, the bit ends up set.
- R7: Changing a polarity bit while the line is steady never sets that line's edge cause.
- R8: `irq_o[k]` is the OR over lines 8k to 8k+7 of (data-in AND level mask) OR (edge cause AND edge mask).
- R9: The edge mask (offset 0x118) gates only the request. A cause still latches and reads back while its mask bit is 0, and it raises the request once the mask bit is set.
- R10: The three mask and polarity registers read back what was written. Writes to 0x110 are ignored, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 32 | Asynchronous input lines |
| addr_i | input | 12 | Register byte offset for reads and writes |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 4 | One request per group of eight lines |

## Verification
A vector table drives the level path with mixed line, polarity and mask words. Some entries cancel a line against its polarity, which shows that the XOR is applied. Others light alternating groups or none at all, which shows that lines land in the right group and that the mask gates them.

Directed tests cover the edge path:
- a rising edge with polarity 0 and a falling edge with polarity 1;
- a cause that stays set after its line falls back;
- a partial clear that keeps the bits written as 1;
- a cause that latches while its edge mask is 0;
- a clearing write that lands on the same edge as an event;
- a polarity flip with the line held steady.

Together these separate the edge path from the level path, and the clear path from the set path.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int          REG_AW    = 12;
   localparam logic [11:0] OFS_POL   = 12'h10C;
   localparam logic [11:0] OFS_DIN   = 12'h110;
   localparam logic [11:0] OFS_CAUSE = 12'h114;
   localparam logic [11:0] OFS_EMASK = 12'h118;
   localparam logic [11:0] OFS_LMASK = 12'h11C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic [W-1:0] pol,
   input  logic         clr_en,
   input  logic [W-1:0] clr_keep,
   output logic [W-1:0] rise,
   output logic [W-1:0] cause
);
   logic [W-1:0] din_q;
   logic [W-1:0] pol_q;
   logic [W-1:0] keep;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         din_q <= '0;
         pol_q <= '0;
      end else begin
         din_q <= din;
         pol_q <= pol;
      end

   // a polarity change this cycle must not count as a line event
   assign rise = din & ~din_q & ~(pol ^ pol_q);
   assign keep = clr_en ? clr_keep : '1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cause <= '0;
      else        cause <= (cause & keep) | rise;
endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
   parameter int W = 32,
   parameter int G = 8
) (
   input  logic [W-1:0]   req,
   output logic [W/G-1:0] grp
);
   localparam int NG = W / G;

   for (genvar k = 0; k < NG; k++) begin : g_grp
      assign grp[k] = |req[k*G +: G];
   end
endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause
   import gpio_irq_pkg::*;
#(
   parameter int NLINES      = 32,
   parameter int GROUP       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NLINES-1:0]        line_i,
   input  logic [REG_AW-1:0]        addr_i,
   input  logic                     wr_en_i,
   input  logic [NLINES-1:0]        wr_data_i,
   output logic [NLINES-1:0]        rd_data_o,
   output logic [NLINES/GROUP-1:0]  irq_o
);
   localparam int NGRP = NLINES / GROUP;

   if (NLINES % GROUP != 0) begin : g_bad_group
      $error("NLINES must be a multiple of GROUP");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NLINES > 32) begin : g_bad_width
      $error("NLINES must fit one register word");
   end

   logic [NLINES-1:0] sync_w, din_w, rise_w, cause_w;
   logic [NLINES-1:0] pol_q, emask_q, lmask_q, req_w;
   logic              cause_wr;

   gpio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_i), .q(sync_w));

   assign din_w    = sync_w ^ pol_q;
   assign cause_wr = wr_en_i && (addr_i == OFS_CAUSE);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         pol_q   <= '0;
         emask_q <= '0;
         lmask_q <= '0;
      end else if (wr_en_i) begin
         case (addr_i)
            OFS_POL:   pol_q   <= wr_data_i;
            OFS_EMASK: emask_q <= wr_data_i;
            OFS_LMASK: lmask_q <= wr_data_i;
            default:   ;
         endcase
      end

   gpio_edge_latch #(.W(NLINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(din_w), .pol(pol_q),
      .clr_en(cause_wr), .clr_keep(wr_data_i),
      .rise(rise_w), .cause(cause_w));

   assign req_w = (din_w & lmask_q) | (cause_w & emask_q);

   gpio_group_or #(.W(NLINES), .G(GROUP)) u_grp (
      .req(req_w), .grp(irq_o));

   always_comb begin
      case (addr_i)
         OFS_POL:   rd_data_o = pol_q;
         OFS_DIN:   rd_data_o = din_w;
         OFS_CAUSE: rd_data_o = cause_w;
         OFS_EMASK: rd_data_o = emask_q;
         OFS_LMASK: rd_data_o = lmask_q;
         default:   rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
   parameter int NL = 32,
   parameter int NG = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NL-1:0] din,
   input logic [NL-1:0] cause,
   input logic [NL-1:0] emask,
   input logic [NL-1:0] lmask,
   input logic          cause_wr,
   input logic [NL-1:0] wr_data,
   input logic [NG-1:0] irq
);
   // R8
   masks_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (emask == '0 && lmask == '0) |-> (irq == '0));

   // R4
   cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cause_wr |=> ((cause & $past(cause)) == $past(cause)));

   // R4
   cause_from_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause & ~$past(cause) & ~($past(din) & ~$past(din, 2))) == '0));

   // R5
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_wr && wr_data == '0 && $stable(din)) |=> (cause == '0));
endmodule

bind gpio_irq_cause gpio_irq_chk #(.NL(NLINES), .NG(NLINES/GROUP)) u_chk (
   .clk(clk), .rst_n(rst_n), .din(din_w), .cause(cause_w),
   .emask(emask_q), .lmask(lmask_q), .cause_wr(cause_wr),
   .wr_data(wr_data_i), .irq(irq_o));

// File: tb/sim_gpio_irq_cause.sv
`timescale 1ns/1ps
module sim_gpio_irq_cause;
   import gpio_irq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] line = '0;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_cause u0 (
      .clk(clk), .rst_n(rst_n), .line_i(line), .addr_i(addr),
      .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_o(irq));

   // level-path vectors: line, polarity, level mask, expected data-in, expected irq
   localparam logic [31:0] TV_LINE [6] = '{32'h0000_0001, 32'h0000_0000, 32'hFF00_0000,
                                           32'h8000_0000, 32'h0001_0080, 32'h0000_FFFF};
   localparam logic [31:0] TV_POL  [6] = '{32'h0, 32'h0000_0400, 32'h0,
                                           32'h8000_0000, 32'h0, 32'hFFFF_0000};
   localparam logic [31:0] TV_LMSK [6] = '{32'h0000_0001, 32'h0000_0400, 32'h00FF_0000,
                                           32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hF000_F000};
   localparam logic [31:0] TV_DIN  [6] = '{32'h0000_0001, 32'h0000_0400, 32'hFF00_0000,
                                           32'h0000_0000, 32'h0001_0080, 32'hFFFF_FFFF};
   localparam logic [3:0]  TV_IRQ  [6] = '{4'b0001, 4'b0010, 4'b0000,
                                           4'b0000, 4'b0101, 4'b1010};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic quiesce();
      line = '0;
      wr(OFS_POL, '0);
      cyc(4);
      wr(OFS_CAUSE, '0);
   endtask

   logic [31:0] v;

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 irq", {28'd0, irq}, 32'd0);
      rd(OFS_POL, v);   chk("R1 pol", v, 32'd0);
      rd(OFS_CAUSE, v); chk("R1 cause", v, 32'd0);
      rd(OFS_EMASK, v); chk("R1 emask", v, 32'd0);
      rd(OFS_LMASK, v); chk("R1 lmask", v, 32'd0);

      // R10 readback, ignored data-in write, unmapped read
      wr(OFS_EMASK, 32'hA5A5_A5A5);
      rd(OFS_EMASK, v); chk("R10 emask readback", v, 32'hA5A5_A5A5);
      wr(OFS_LMASK, 32'h5A5A_5A5A);
      rd(OFS_LMASK, v); chk("R10 lmask readback", v, 32'h5A5A_5A5A);
      wr(OFS_DIN, 32'hFFFF_FFFF);
      rd(OFS_DIN, v); chk("R10 din write ignored", v, 32'd0);
      rd(12'h120, v); chk("R10 unmapped read", v, 32'd0);
      wr(OFS_EMASK, '0);
      wr(OFS_LMASK, '0);

      // R2 R3 R8 level-path table
      for (int t = 0; t < 6; t++) begin
         wr(OFS_POL, TV_POL[t]);
         wr(OFS_LMASK, TV_LMSK[t]);
         line = TV_LINE[t];
         cyc(3);
         rd(OFS_DIN, v); chk($sformatf("R2 din vector %0d", t), v, TV_DIN[t]);
         chk($sformatf("R8 irq vector %0d", t), {28'd0, irq}, {28'd0, TV_IRQ[t]});
      end
      // R3 level not latched
      wr(OFS_POL, '0);
      wr(OFS_LMASK, 32'h0000_0001);
      line = 32'h1; cyc(3);
      chk("R3 level high", {28'd0, irq}, 32'd1);
      line = 32'h0; cyc(3);
      chk("R3 level drops", {28'd0, irq}, 32'd0);
      wr(OFS_LMASK, '0);
      quiesce();

      // R4 rising edge, sticky
      wr(OFS_EMASK, 32'h0000_0001);
      line = 32'h1; cyc(4);
      rd(OFS_CAUSE, v); chk("R4 rise cause", v, 32'h1);
      chk("R4 rise irq", {28'd0, irq}, 32'h1);
      line = 32'h0; cyc(4);
      rd(OFS_CAUSE, v); chk("R4 sticky", v, 32'h1);

      // R5 partial clear
      wr(OFS_CAUSE, 32'hFFFF_FFFE);
      rd(OFS_CAUSE, v); chk("R5 clear bit0", v, 32'h0);
      line = 32'h0000_0300; cyc(4);
      rd(OFS_CAUSE, v); chk("R5 two set", v, 32'h0000_0300);
      wr(OFS_CAUSE, 32'hFFFF_FEFF);
      rd(OFS_CAUSE, v); chk("R5 keep ones", v, 32'h0000_0200);
      quiesce();

      // R9 masked cause still latches
      wr(OFS_EMASK, '0);
      line = 32'h0010_0000; cyc(4);
      rd(OFS_CAUSE, v); chk("R9 latched while masked", v, 32'h0010_0000);
      chk("R9 no irq while masked", {28'd0, irq}, 32'd0);
      wr(OFS_EMASK, 32'h0010_0000);
      chk("R9 irq after unmask", {28'd0, irq}, 32'b0100);
      wr(OFS_EMASK, '0);
      quiesce();

      // R6 set wins over same-edge clear
      @(negedge clk);
      line = 32'h0000_0004;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      addr = OFS_CAUSE; wr_data = 32'h0; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      rd(OFS_CAUSE, v); chk("R6 set wins", v, 32'h0000_0004);
      quiesce();

      // R7 polarity flip alone, then R4 falling edge with polarity 1
      wr(OFS_POL, 32'h0000_0001);
      cyc(4);
      rd(OFS_CAUSE, v); chk("R7 polarity set no event", v, 32'h0);
      wr(OFS_POL, 32'h0);
      cyc(4);
      wr(OFS_POL, 32'h0000_0001);
      cyc(4);
      rd(OFS_CAUSE, v); chk("R7 second flip no event", v, 32'h0);
      line = 32'h1; cyc(4);
      rd(OFS_CAUSE, v); chk("R4 no event on rise with pol1", v, 32'h0);
      line = 32'h0; cyc(4);
      rd(OFS_CAUSE, v); chk("R4 falling edge with pol1", v, 32'h1);

      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule